// File: doc/BRIEF.md
# Masked Vector Lane Sequencer

This block issues one vector ALU instruction across a row of parallel lanes. Element `e` of a vector register lives in lane `e mod NUM_LANES`. The sequencer walks the vector in element groups, one group per clock. In each group every lane handles the element whose index is the group base plus the lane number. It keeps going until the vector-length count is used up. The external vector register file reads its operands through the per-lane element indices, and the sequencer returns per-lane results and write enables.

Conditional execution comes from a flag vector that is captured when the instruction is issued. In masked mode a lane writes only when the flag of its element is set. The merge opcode always writes in-range elements: it takes the second operand where the flag is set and the first operand where it is clear. A `busy` signal covers the whole instruction, and a one-cycle `done` strobe marks completion.

Top module: `vmask_lane_seq`

## Requirements
- R1: During and straight after reset, `busy`, `done` and every bit of `lane_wen` are 0.
- R2: An issue (`issue_valid` while `busy` is low) with an effective length L>0 raises `busy` on the next cycle. `busy` then stays high for exactly ceil(L/NUM_LANES) cycles, one element group per cycle. `done` is high only in the last of those cycles, and `busy` is low on the cycle after it.
- R3: In group g (counting from 0), lane l drives element index g*NUM_LANES+l on its slice of `lane_idx`. Lane l occupies bits [l*IDX_W +: IDX_W].
- R4: In a final group that is only partly filled, every lane whose element index is L or greater has its write enable low.
- R5: For opcodes 0 to 6, an in-range lane writes always when `issue_masked` was 0 at issue. When `issue_masked` was 1, it writes only if flag bit [index] is 1.
- R6: Opcode 7 (merge) writes every in-range lane regardless of `issue_masked`. Its result is operand B when flag bit [index] is 1 and operand A when that bit is 0.
- R7: An issue with L=0 leaves `busy` low, pulses `done` on the next cycle only, and produces no write enable.
- R8: `issue_valid` while `busy` is high is ignored: the running instruction's groups, indices, enables and length are unchanged.
- R9: A requested length above MAX_VLEN is treated as MAX_VLEN.
- R10: Opcode results are taken modulo 2^DATA_W, using the lane's operands A and B: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 unsigned minimum, 6 unsigned maximum.
- R11: Flags, opcode and mask mode are captured at issue. Changes on those inputs while `busy` is high do not affect the running instruction.
- R12: Whenever `busy` is low, `lane_wen` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction request |
| issue_op | input | 3 | Opcode (see R10, R6) |
| issue_masked | input | 1 | Flag-masked execution for opcodes 0 to 6 |
| issue_vlen | input | VL_W | Requested vector length |
| issue_flags | input | MAX_VLEN | Flag bit per element |
| lane_opa | input | NUM_LANES*DATA_W | Operand A per lane, for the element on `lane_idx` |
| lane_opb | input | NUM_LANES*DATA_W | Operand B per lane |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion strobe |
| lane_idx | output | NUM_LANES*IDX_W | Element index per lane |
| lane_wen | output | NUM_LANES | Write enable per lane |
| lane_result | output | NUM_LANES*DATA_W | Result per lane |

## Verification
The assertions assume that the operand inputs follow `lane_idx` in the same cycle, as a register file read does. They also assume that no issue arrives on the cycle during reset release. The bench meets both: it derives the operands combinationally from the index outputs, and it drives requests only on falling edges after reset has dropped. Every opcode, both mask modes and every length from 0 to one past the maximum are swept. On every third instruction the bench keeps `issue_valid` asserted and toggles the flags while the instruction runs. This pushes the busy hold-off and the capture-at-issue behaviour without leaving those assumptions.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

    typedef enum logic [2:0] {
        VOP_ADD   = 3'd0,
        VOP_SUB   = 3'd1,
        VOP_AND   = 3'd2,
        VOP_OR    = 3'd3,
        VOP_XOR   = 3'd4,
        VOP_MINU  = 3'd5,
        VOP_MAXU  = 3'd6,
        VOP_MERGE = 3'd7
    } vop_e;

    typedef struct packed {
        vop_e op;
        logic masked;
    } vctl_t;

    // Whether a lane commits its element, given range and flag.
    function automatic logic lane_commit(vctl_t ctl, logic in_range, logic flag);
        logic w;
        if (!in_range)
            w = 1'b0;
        else if (ctl.op == VOP_MERGE)
            w = 1'b1;
        else if (ctl.masked)
            w = flag;
        else
            w = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/vmask_ctrl.sv
module vmask_ctrl
    import vmask_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int MAX_VLEN  = 16,
    parameter int VL_W      = $clog2(MAX_VLEN + 1),
    parameter int CNT_W     = $clog2(MAX_VLEN + NUM_LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  vctl_t               issue_ctl,
    input  logic [VL_W-1:0]     issue_vlen,
    input  logic [MAX_VLEN-1:0] issue_flags,
    output logic                busy,
    output logic                done,
    output logic [CNT_W-1:0]    base,
    output logic [CNT_W-1:0]    vlen_q,
    output vctl_t               ctl_q,
    output logic [MAX_VLEN-1:0] flags_q
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(NUM_LANES);
    localparam logic [CNT_W-1:0] VMAX = CNT_W'(MAX_VLEN);

    logic             accept;
    logic             last_grp;
    logic             zero_done;
    logic [CNT_W-1:0] vlen_ext;
    logic [CNT_W-1:0] vlen_c;

    assign accept   = issue_valid && !busy;
    assign vlen_ext = CNT_W'(issue_vlen);
    assign vlen_c   = (vlen_ext > VMAX) ? VMAX : vlen_ext;
    assign last_grp = busy && ((base + STEP) >= vlen_q);
    assign done     = last_grp || zero_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            base      <= '0;
            vlen_q    <= '0;
            ctl_q     <= '{op: VOP_ADD, masked: 1'b0};
            flags_q   <= '0;
            zero_done <= 1'b0;
        end else begin
            zero_done <= accept && (vlen_c == '0);
            if (accept) begin
                busy    <= (vlen_c != '0);
                base    <= '0;
                vlen_q  <= vlen_c;
                ctl_q   <= issue_ctl;
                flags_q <= issue_flags;
            end else if (busy) begin
                if (last_grp)
                    busy <= 1'b0;
                else
                    base <= base + STEP;
            end
        end
    end

endmodule

// File: rtl/vmask_lane.sv
module vmask_lane
    import vmask_pkg::*;
#(
    parameter int LANE      = 0,
    parameter int MAX_VLEN  = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 5,
    parameter int IDX_W     = $clog2(MAX_VLEN)
) (
    input  logic                active,
    input  logic [CNT_W-1:0]    base,
    input  logic [CNT_W-1:0]    vlen_q,
    input  vctl_t               ctl,
    input  logic [MAX_VLEN-1:0] flags_q,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    output logic [IDX_W-1:0]    idx,
    output logic                wen,
    output logic [DATA_W-1:0]   result
);

    logic [CNT_W-1:0] elem;
    logic             in_range;
    logic             flag;

    assign elem     = base + CNT_W'(LANE);
    assign idx      = elem[IDX_W-1:0];
    assign in_range = active && (elem < vlen_q);
    assign flag     = in_range ? flags_q[idx] : 1'b0;
    assign wen      = lane_commit(ctl, in_range, flag);

    always_comb begin
        unique case (ctl.op)
            VOP_ADD:   result = opa + opb;
            VOP_SUB:   result = opa - opb;
            VOP_AND:   result = opa & opb;
            VOP_OR:    result = opa | opb;
            VOP_XOR:   result = opa ^ opb;
            VOP_MINU:  result = (opa < opb) ? opa : opb;
            VOP_MAXU:  result = (opa > opb) ? opa : opb;
            VOP_MERGE: result = flag ? opb : opa;
            default:   result = '0;
        endcase
    end

endmodule

// File: rtl/vmask_lane_seq.sv
module vmask_lane_seq
    import vmask_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int MAX_VLEN  = 16,
    parameter int DATA_W    = 8,
    parameter int VL_W      = $clog2(MAX_VLEN + 1) + 1,
    parameter int IDX_W     = $clog2(MAX_VLEN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue_valid,
    input  logic [2:0]                    issue_op,
    input  logic                          issue_masked,
    input  logic [VL_W-1:0]               issue_vlen,
    input  logic [MAX_VLEN-1:0]           issue_flags,
    input  logic [NUM_LANES*DATA_W-1:0]   lane_opa,
    input  logic [NUM_LANES*DATA_W-1:0]   lane_opb,
    output logic                          busy,
    output logic                          done,
    output logic [NUM_LANES*IDX_W-1:0]    lane_idx,
    output logic [NUM_LANES-1:0]          lane_wen,
    output logic [NUM_LANES*DATA_W-1:0]   lane_result
);

    localparam int CNT_W = $clog2(MAX_VLEN + NUM_LANES) + 1;

    vctl_t               issue_ctl;
    vctl_t               ctl_q;
    logic [CNT_W-1:0]    base;
    logic [CNT_W-1:0]    vlen_q;
    logic [MAX_VLEN-1:0] flags_q;

    assign issue_ctl = '{op: vop_e'(issue_op), masked: issue_masked};

    vmask_ctrl #(
        .NUM_LANES (NUM_LANES),
        .MAX_VLEN  (MAX_VLEN),
        .VL_W      (VL_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_ctl   (issue_ctl),
        .issue_vlen  (issue_vlen),
        .issue_flags (issue_flags),
        .busy        (busy),
        .done        (done),
        .base        (base),
        .vlen_q      (vlen_q),
        .ctl_q       (ctl_q),
        .flags_q     (flags_q)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        vmask_lane #(
            .LANE     (l),
            .MAX_VLEN (MAX_VLEN),
            .DATA_W   (DATA_W),
            .CNT_W    (CNT_W),
            .IDX_W    (IDX_W)
        ) u_lane (
            .active  (busy),
            .base    (base),
            .vlen_q  (vlen_q),
            .ctl     (ctl_q),
            .flags_q (flags_q),
            .opa     (lane_opa[l*DATA_W +: DATA_W]),
            .opb     (lane_opb[l*DATA_W +: DATA_W]),
            .idx     (lane_idx[l*IDX_W +: IDX_W]),
            .wen     (lane_wen[l]),
            .result  (lane_result[l*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/vmask_lane_seq_chk.sv
module vmask_lane_seq_chk #(
    parameter int NUM_LANES = 4,
    parameter int MAX_VLEN  = 16,
    parameter int VL_W      = 6,
    parameter int IDX_W     = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       issue_valid,
    input logic [VL_W-1:0]            issue_vlen,
    input logic                       busy,
    input logic                       done,
    input logic [NUM_LANES-1:0]       lane_wen,
    input logic [NUM_LANES*IDX_W-1:0] lane_idx
);

    // R12
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (lane_wen == '0));

    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy && issue_vlen == '0) |=> (done && !busy));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !busy && issue_vlen != '0) |=> busy);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);

    // R8
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && issue_valid) |=> busy);

    // R3
    first_group_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (lane_idx[IDX_W-1:0] == '0));

    // R3
    group_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (lane_idx[IDX_W-1:0] ==
            $past(lane_idx[IDX_W-1:0]) + IDX_W'(NUM_LANES)));

endmodule

bind vmask_lane_seq vmask_lane_seq_chk #(
    .NUM_LANES (NUM_LANES),
    .MAX_VLEN  (MAX_VLEN),
    .VL_W      (VL_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_vlen  (issue_vlen),
    .busy        (busy),
    .done        (done),
    .lane_wen    (lane_wen),
    .lane_idx    (lane_idx)
);

// File: tb/vmask_lane_seq_tb.sv
module vmask_lane_seq_tb;

    localparam int N   = 4;
    localparam int M   = 16;
    localparam int DW  = 8;
    localparam int VLW = $clog2(M + 1) + 1;
    localparam int IW  = $clog2(M);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              issue_valid = 1'b0;
    logic [2:0]        issue_op = '0;
    logic              issue_masked = 1'b0;
    logic [VLW-1:0]    issue_vlen = '0;
    logic [M-1:0]      issue_flags = '0;
    logic [N*DW-1:0]   lane_opa;
    logic [N*DW-1:0]   lane_opb;
    logic              busy;
    logic              done;
    logic [N*IW-1:0]   lane_idx;
    logic [N-1:0]      lane_wen;
    logic [N*DW-1:0]   lane_result;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] fa(int i);
        return DW'(i * 37 + 11);
    endfunction

    function automatic logic [DW-1:0] fb(int i);
        return DW'(i * 91 + 250);
    endfunction

    for (genvar l = 0; l < N; l++) begin : g_src
        assign lane_opa[l*DW +: DW] = fa(int'(lane_idx[l*IW +: IW]));
        assign lane_opb[l*DW +: DW] = fb(int'(lane_idx[l*IW +: IW]));
    end

    vmask_lane_seq #(.NUM_LANES(N), .MAX_VLEN(M), .DATA_W(DW)) u_dut (
        .clk, .rst, .issue_valid, .issue_op, .issue_masked, .issue_vlen,
        .issue_flags, .lane_opa, .lane_opb, .busy, .done, .lane_idx,
        .lane_wen, .lane_result
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int exp_res(int op, int a, int b, bit f);
        int r;
        case (op)
            0: r = (a + b) & 255;
            1: r = (a - b) & 255;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = (a < b) ? a : b;
            6: r = (a > b) ? a : b;
            default: r = f ? b : a;
        endcase
        return r;
    endfunction

    task automatic run_instr(int op, bit msk, int vl, logic [M-1:0] fl, bit disturb);
        int vlc;
        int grps;
        @(negedge clk);
        issue_valid  = 1'b1;
        issue_op     = 3'(op);
        issue_masked = msk;
        issue_vlen   = VLW'(vl);
        issue_flags  = fl;
        @(negedge clk);
        vlc  = (vl > M) ? M : vl;
        grps = (vlc + N - 1) / N;
        if (disturb) begin
            issue_valid  = 1'b1;
            issue_vlen   = VLW'(3);
            issue_op     = 3'(7 - op);
            issue_masked = ~msk;
            issue_flags  = ~fl;
        end else begin
            issue_valid = 1'b0;
        end
        if (grps == 0) begin
            chk("R7 done", int'(done), 1);
            chk("R7 busy", int'(busy), 0);
            chk("R7 wen", int'(lane_wen), 0);
            issue_valid = 1'b0;
            @(negedge clk);
            chk("R7 done width", int'(done), 0);
            chk("R7 busy after", int'(busy), 0);
            return;
        end
        for (int g = 0; g < grps; g++) begin
            chk(disturb ? "R8 busy" : "R2 busy", int'(busy), 1);
            chk(vl > M ? "R9 done" : "R2 done", int'(done), (g == grps - 1) ? 1 : 0);
            for (int l = 0; l < N; l++) begin
                int  e;
                bit  inr;
                bit  f;
                bit  ew;
                string rq;
                e   = g * N + l;
                inr = (e < vlc);
                f   = inr ? fl[e] : 1'b0;
                if (op == 7)
                    ew = inr;
                else
                    ew = inr && (!msk || f);
                if (!inr)
                    rq = (vl > M) ? "R9 wen" : "R4 wen";
                else if (op == 7)
                    rq = "R6 wen";
                else if (disturb)
                    rq = "R11 wen";
                else
                    rq = "R5 wen";
                chk("R3 idx", int'(lane_idx[l*IW +: IW]), e % M);
                chk(rq, int'(lane_wen[l]), int'(ew));
                if (ew)
                    chk(op == 7 ? "R6 result" : "R10 result",
                        int'(lane_result[l*DW +: DW]),
                        exp_res(op, int'(fa(e)), int'(fb(e)), f));
            end
            if (g == grps - 1)
                issue_valid = 1'b0;
            @(negedge clk);
        end
        chk("R2 busy end", int'(busy), 0);
        chk("R2 done end", int'(done), 0);
        chk("R12 idle wen", int'(lane_wen), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 wen in reset", int'(lane_wen), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 wen after reset", int'(lane_wen), 0);
        for (int op = 0; op < 8; op++) begin
            for (int msk = 0; msk < 2; msk++) begin
                for (int vl = 0; vl <= M + 1; vl++) begin
                    seed = seed * 32'd1664525 + 32'd1013904223;
                    run_instr(op, msk[0], vl, seed[M+7:8], (vl % 3) == 0);
                end
            end
        end
        run_instr(7, 1'b0, 9, '1, 1'b0);
        run_instr(7, 1'b1, 9, '0, 1'b0);
        run_instr(0, 1'b1, 16, '0, 1'b0);
        ended = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule